// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers nine external level-sensitive interrupt inputs and drives three active-high request lines toward an upstream interrupt controller. Each input first crosses into the local clock domain through a two-flop synchroniser. A shared polarity word then decides whether the input counts as active when high or when low.

Every request line owns one register. Its low half holds an enable bit per source. Its upper half holds a pending bit per source. A source reaches a line only when that line's enable bit for it is set, so software routes a source by choosing which line register enables it. A pending bit stays set until software writes a one to it. A line is asserted while any of its pending bits is set.

Software finds the cause by reading the line register and taking the highest set pending bit. Access goes through a plain 32-bit register port with word addresses and a single-cycle write. Read data is combinational from the addressed register.

Top module: `lvl_irq_router`

## Requirements
- R1: While reset is applied and directly after it, every register reads as zero and all three request lines are low.
- R2: Word address 0 is the polarity word. Bit i set to 1 makes source i active when its input is high. Bit i cleared to 0 makes source i active when its input is low. Bits 31..9 read zero and ignore writes.
- R3: Word address 1+n (n = 0..2) is the register of request line n. Bits 8..0 are the enable bits, with bit i belonging to source i, and they read back what was written.
- R4: An input change reaches the pending bit on the third rising edge after it appears, through two synchroniser flops and the pending flop. If the source is active and enabled in line n, pending bit 16+i of line n then reads 1.
- R5: A set pending bit stays set after its source becomes inactive, until it is acknowledged.
- R6: Writing 1 to bit 16+i of a line register clears that pending bit on the write edge. Writing 0 there leaves it unchanged. If the source is still active and enabled, the bit is set again on the following edge.
- R7: A source whose enable bit in line n is 0 never sets a pending bit in line n. Each line is routed independently of the other lines.
- R8: Request line n is high exactly while at least one pending bit of line n is set. It follows that pending state with no added delay.
- R9: In line registers, bits 15..9 and 31..25 read zero and ignore writes. Word addresses 4 and above read zero, and a write to them changes no register.
- R10: Writing 0x01FF0000 to all three line registers clears every pending bit, masks every source, and drops all request lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_src | input | 9 | External level interrupt inputs, asynchronous |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, zero when not selected |
| irq_out | output | 3 | Active-high request lines toward the upstream controller |

## Verification
An input edge shows up in the pending field and on the request line three clock edges after it is applied. The bench samples one edge before that point to see the old value, and on the third edge to see the new one. A polarity or enable write acts on the edge that follows the write edge. An acknowledge takes effect on the write edge itself. The bench therefore reads back right after the write edge to see the cleared bit, and reads again one edge later to see the bit set again. Inputs are driven on falling edges and outputs are sampled one nanosecond after, so every expected value falls at a known number of rising edges.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
    localparam int NSRC    = 9;   // interrupt sources
    localparam int NLINE   = 3;   // request lines
    localparam int AW      = 4;   // word address width
    localparam int DW      = 32;  // register width
    localparam int ACK_LSB = 16;  // first pending/acknowledge bit
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_out = st_q.s2;
endmodule

// File: rtl/lirq_line.sv
module lirq_line #(
    parameter int N_SRC = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] act,     // polarity-adjusted, synchronised
    input  logic             wr,      // this line's register written
    input  logic [N_SRC-1:0] en_wr,
    input  logic [N_SRC-1:0] ack_wr,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] pend_q,
    output logic             irq
);
    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] pend;
    } line_t;

    line_t            st_d, st_q;
    logic [N_SRC-1:0] ack;

    always_comb begin
        st_d = st_q;
        ack  = wr ? ack_wr : '0;
        // level capture is sticky; an acknowledge wins on its own edge
        st_d.pend = (st_q.pend | (act & st_q.en)) & ~ack;
        if (wr) st_d.en = en_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign pend_q = st_q.pend;
    assign irq    = |st_q.pend;
endmodule

// File: rtl/lirq_rdmux.sv
module lirq_rdmux #(
    parameter int N_SRC   = 9,
    parameter int N_LINE  = 3,
    parameter int ADDR_W  = 4,
    parameter int DW      = 32,
    parameter int ACK_LSB = 16
) (
    input  logic                          sel,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DW-1:0]                 pol_word,
    input  logic [N_LINE-1:0][N_SRC-1:0]  en_all,
    input  logic [N_LINE-1:0][N_SRC-1:0]  pend_all,
    output logic [DW-1:0]                 rdata
);
    always_comb begin
        rdata = '0;
        if (sel) begin
            if (addr == '0) rdata = pol_word;
            for (int n = 0; n < N_LINE; n++) begin
                if (addr == ADDR_W'(n + 1)) begin
                    rdata[N_SRC-1:0]           = en_all[n];
                    rdata[ACK_LSB +: N_SRC]    = pend_all[n];
                end
            end
        end
    end
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
    import lirq_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int N_LINE = NLINE,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_src,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [N_LINE-1:0] irq_out
);
    localparam logic [DW-1:0] LOW_ONES = DW'((64'd1 << N_SRC) - 64'd1);

    // polarity word kept full width; undefined bits are constant zero
    typedef struct packed {
        logic [DW-1:0] pol;
    } pol_t;

    pol_t                        pol_d, pol_q;
    logic [N_SRC-1:0]            src_sync;
    logic [N_SRC-1:0]            act;
    logic [N_LINE-1:0]           line_wr;
    logic [N_LINE-1:0][N_SRC-1:0] en_w;
    logic [N_LINE-1:0][N_SRC-1:0] pend_w;

    always_comb begin
        pol_d = pol_q;
        if (bus_sel && bus_wr && bus_addr == '0)
            pol_d.pol = bus_wdata & LOW_ONES;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pol_q <= '0;
        else        pol_q <= pol_d;
    end

    lirq_sync #(.W(N_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_src),
        .q_out (src_sync)
    );

    // active when the synchronised level equals the polarity bit
    assign act = ~(src_sync ^ pol_q.pol[N_SRC-1:0]);

    for (genvar g = 0; g < N_LINE; g++) begin : g_line
        assign line_wr[g] = bus_sel && bus_wr && (bus_addr == ADDR_W'(g + 1));

        lirq_line #(.N_SRC(N_SRC)) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .act    (act),
            .wr     (line_wr[g]),
            .en_wr  (bus_wdata[N_SRC-1:0]),
            .ack_wr (bus_wdata[ACK_LSB +: N_SRC]),
            .en_q   (en_w[g]),
            .pend_q (pend_w[g]),
            .irq    (irq_out[g])
        );
    end

    lirq_rdmux #(
        .N_SRC   (N_SRC),
        .N_LINE  (N_LINE),
        .ADDR_W  (ADDR_W),
        .DW      (DW),
        .ACK_LSB (ACK_LSB)
    ) u_rdmux (
        .sel      (bus_sel),
        .addr     (bus_addr),
        .pol_word (pol_q.pol),
        .en_all   (en_w),
        .pend_all (pend_w),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk
    import lirq_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int N_LINE = NLINE,
    parameter int ADDR_W = AW
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_sel,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [N_SRC-1:0]              ack_bits,
    input logic [DW-1:0]                 bus_rdata,
    input logic [N_LINE-1:0]             irq_out,
    input logic [N_LINE-1:0][N_SRC-1:0]  en_all,
    input logic [N_LINE-1:0][N_SRC-1:0]  pend_all
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) reset_quiet_chk: assert (irq_out == '0 && pend_all == '0);
    end

    // R2
    pol_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == '0) |-> (bus_rdata[DW-1:N_SRC] == '0));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr > ADDR_W'(N_LINE)) |-> (bus_rdata == '0));

    for (genvar n = 0; n < N_LINE; n++) begin : g_n
        for (genvar i = 0; i < N_SRC; i++) begin : g_i
            // R6
            ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_sel && bus_wr && bus_addr == ADDR_W'(n + 1) && ack_bits[i])
                |=> !pend_all[n][i]);
            // R5
            pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_all[n][i] &&
                 !(bus_sel && bus_wr && bus_addr == ADDR_W'(n + 1) && ack_bits[i]))
                |=> pend_all[n][i]);
            // R7
            masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!pend_all[n][i] && !en_all[n][i]) |=> !pend_all[n][i]);
        end
    end
endmodule

bind lvl_irq_router lirq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ack_bits  (bus_wdata[lirq_pkg::ACK_LSB +: lirq_pkg::NSRC]),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .en_all    (en_w),
    .pend_all  (pend_w)
);

// File: tb/test_lvl_irq_router.sv
`timescale 1ns/1ps
module test_lvl_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  irq_src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    lvl_irq_router i_lvl_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_src   (irq_src),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // {pol, src, en0, en1, en2, exp0, exp1, exp2}, 9 bits each
    localparam logic [71:0] TBL [6] = '{
        {9'h1FF, 9'h000, 9'h1FF, 9'h1FF, 9'h1FF, 9'h000, 9'h000, 9'h000},
        {9'h1FF, 9'h1FF, 9'h001, 9'h100, 9'h0F0, 9'h001, 9'h100, 9'h0F0},
        {9'h000, 9'h000, 9'h0AA, 9'h155, 9'h000, 9'h0AA, 9'h155, 9'h000},
        {9'h0F0, 9'h0F0, 9'h003, 9'h1FF, 9'h010, 9'h003, 9'h1FF, 9'h010},
        {9'h0F0, 9'h10F, 9'h1FF, 9'h1FF, 9'h1FF, 9'h000, 9'h000, 9'h000},
        {9'h155, 9'h055, 9'h1FF, 9'h100, 9'h081, 9'h0FF, 9'h000, 9'h081}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] line_word(input logic [8:0] pend, input logic [8:0] en);
        return {7'b0, pend, 7'b0, en};
    endfunction

    initial begin
        logic [31:0] d;
        logic [71:0] v;
        logic [8:0]  en  [3];
        logic [8:0]  exp [3];

        cyc(3);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(4'(a), d); chk("R1 reset read", d, 32'h0);
        end
        chk("R1 reset irq", {29'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 after reset irq", {29'b0, irq_out}, 32'h0);

        // R2 / R9: polarity readback, undefined bits dropped
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d); chk("R2 pol readback", d, 32'h0000_01FF);

        // R3 / R9: enable readback, undefined bits dropped; inputs low so none active
        irq_src = '0; cyc(3);
        wr(4'd1, 32'hFE00_FFFF);
        rd(4'd1, d); chk("R3 enable readback", d, 32'h0000_01FF);
        cyc(3);
        rd(4'd1, d); chk("R3 no pending while inactive", d, 32'h0000_01FF);

        // R4 / R8: three-edge latency of source 0 into line 0
        wr(4'd1, 32'h01FF_0001);
        irq_src[0] = 1'b1;
        cyc(2);
        chk("R4 not yet pending", {29'b0, irq_out}, 32'h0);
        cyc(1);
        chk("R4 R8 irq0 on third edge", {29'b0, irq_out}, 32'h1);
        rd(4'd1, d); chk("R4 pending bit 16", d, line_word(9'h001, 9'h001));

        // R5: sticky after source drops
        irq_src[0] = 1'b0;
        cyc(5);
        rd(4'd1, d); chk("R5 pending sticky", d, line_word(9'h001, 9'h001));
        chk("R5 irq sticky", {29'b0, irq_out}, 32'h1);

        // R6: writing zero to pending does nothing, one clears
        wr(4'd1, 32'h0000_0001);
        rd(4'd1, d); chk("R6 write zero keeps", d, line_word(9'h001, 9'h001));
        wr(4'd1, 32'h0001_0001);
        rd(4'd1, d); chk("R6 ack clears", d, line_word(9'h000, 9'h001));
        chk("R8 irq drops", {29'b0, irq_out}, 32'h0);

        // R6: re-pend one edge after ack while still active
        irq_src[0] = 1'b1;
        cyc(4);
        wr(4'd1, 32'h0001_0001);
        rd(4'd1, d); chk("R6 cleared on write edge", d, line_word(9'h000, 9'h001));
        cyc(1);
        rd(4'd1, d); chk("R6 set again next edge", d, line_word(9'h001, 9'h001));

        // R7: line 1 not enabled for source 0 stays quiet
        rd(4'd2, d); chk("R7 unrouted line quiet", d, 32'h0);
        chk("R7 irq1 irq2 low", {29'b0, irq_out}, 32'h1);

        // R9: unmapped addresses
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd0, d); chk("R9 pol untouched", d, 32'h0000_01FF);
        rd(4'd2, d); chk("R9 line1 untouched", d, 32'h0);
        rd(4'd4, d); chk("R9 addr4 zero", d, 32'h0);
        rd(4'd15, d); chk("R9 addr15 zero", d, 32'h0);

        // R2 R7 R8: polarity and routing table
        for (int k = 0; k < 6; k++) begin
            v = TBL[k];
            en[0] = v[53:45]; en[1] = v[44:36]; en[2] = v[35:27];
            exp[0] = v[26:18]; exp[1] = v[17:9]; exp[2] = v[8:0];
            for (int n = 0; n < 3; n++) wr(4'(n + 1), 32'h01FF_0000);
            wr(4'd0, {23'b0, v[71:63]});
            irq_src = v[62:54];
            cyc(4);
            for (int n = 0; n < 3; n++) wr(4'(n + 1), {7'b0, 9'h1FF, 7'b0, en[n]});
            cyc(3);
            for (int n = 0; n < 3; n++) begin
                rd(4'(n + 1), d);
                chk($sformatf("R2 R7 table %0d line %0d", k, n), d, line_word(exp[n], en[n]));
                chk($sformatf("R8 table %0d irq %0d", k, n), {31'b0, irq_out[n]}, {31'b0, |exp[n]});
            end
        end

        // R10: clearing write on every line
        for (int n = 0; n < 3; n++) wr(4'(n + 1), 32'h01FF_0000);
        cyc(2);
        for (int n = 0; n < 3; n++) begin
            rd(4'(n + 1), d); chk("R10 line cleared", d, 32'h0);
        end
        chk("R10 irq low", {29'b0, irq_out}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule